// File: doc/BRIEF.md
# Serial Transmit Holding and Shift Path

This block is the transmit half of a byte-wide asynchronous serial port. A processor writes bytes over an 8-bit data bus with a single write strobe. The bytes wait in a holding stage. That stage is a single byte deep, or 16 deep when the queue mode input is set. A shift register then sends each byte on one serial line, timed by an enable pulse that arrives at sixteen times the bit rate. The frame is fixed: one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity.

Two status outputs report emptiness at two depths. The first says that no byte is waiting in the holding stage. The second says that the holding stage is empty and the shift register is also idle. Software can use the first to refill the stage. It can use the second to know that the serial line has fully drained. When a byte is waiting at the end of a stop bit, the next start bit follows at once, so a stream of bytes goes out with no idle time between frames.

Top module: `uart_tx_path`

## Requirements
- R1: After reset the serial line `tx` is 1, `hold_empty` is 1 and `tx_idle` is 1.
- R2: Each frame is a start bit of 0, then eight data bits with bit 0 sent first, then a stop bit of 1. Every bit lasts exactly 16 pulses of `baud_tick`.
- R3: `hold_empty` is 0 while at least one byte waits in the holding stage. It becomes 1 in the same cycle that the last waiting byte moves into the shift register, and that is also the cycle in which the start bit begins on `tx`.
- R4: `tx_idle` is 1 only when the holding stage is empty and no frame is in progress. While a frame is being sent it is 0, even when `hold_empty` is 1.
- R5: With `fifo_en` = 0 the holding stage stores one byte. A write is accepted when that byte slot is empty. A write made while a byte is still waiting there is dropped, and the dropped byte is never sent.
- R6: With `fifo_en` = 1 the holding stage stores up to 16 bytes and sends them in the order they were written. A write made while 16 bytes are waiting is dropped.
- R7: When a stop bit ends while a byte is waiting, the next start bit begins on that same pulse. The falling edges of consecutive back-to-back frames are therefore exactly 160 pulses apart.
- R8: `tx` changes only in a cycle in which `baud_tick` is 1. With no pulses, written bytes stay queued and the line stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects the 16-deep queue, 0 selects a single holding byte; change only while `tx_idle` is 1 |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| tx | output | 1 | Serial output line, 1 when idle |
| hold_empty | output | 1 | 1 when no byte waits in the holding stage |
| tx_idle | output | 1 | 1 when both the holding stage and the shift register are empty |

## Verification
A wrong count in the holding stage shows at the ports in one of two ways: a byte goes missing, or a byte is sent twice in the decoded stream. It also shows as a `hold_empty` that disagrees with the number of bytes written minus the number of start bits seen. These faults appear within one frame time of the write that causes them. A wrong bit counter or tick counter stretches or shortens a bit. That corrupts the mid-bit samples of the first affected frame, or moves the spacing of back-to-back start edges away from 160 pulses. A shift register that loads late or too early shows as a gap between frames, or as `tx_idle` rising while a frame is still on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              limit_one,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [CNT_W-1:0]             count;
    } hold_st_t;

    hold_st_t st_q, st_d;
    logic     full;
    logic     do_push;
    logic     do_pop;

    assign full      = limit_one ? (st_q.count != '0) : (st_q.count == CNT_W'(DEPTH));
    assign empty     = (st_q.count == '0);
    assign head_data = st_q.mem[st_q.rptr];
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wptr] = push_data;
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (st_q.count == $past(st_q.count))); // R6
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_one && $stable(limit_one)) |-> (st_q.count <= CNT_W'(1))); // R5
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R3
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] load_data,
    output logic              pop,
    output logic              busy,
    output logic              tx
);
    localparam int CW = $clog2(OS_RATE);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        sh_state_e         state;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic              line;
    } sh_st_t;

    sh_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (tick) begin
            if (st_q.state == SH_IDLE) begin
                if (avail) begin
                    pop        = 1'b1;
                    st_d.state = SH_START;
                    st_d.shreg = load_data;
                    st_d.cnt   = '0;
                    st_d.line  = 1'b0;
                end
            end else if (st_q.cnt != CW'(OS_RATE - 1)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
                case (st_q.state)
                    SH_START: begin
                        st_d.state = SH_DATA;
                        st_d.idx   = '0;
                        st_d.line  = st_q.shreg[0];
                    end
                    SH_DATA: begin
                        if (st_q.idx == IW'(DATA_W - 1)) begin
                            st_d.state = SH_STOP;
                            st_d.line  = 1'b1;
                        end else begin
                            st_d.idx   = st_q.idx + 1'b1;
                            st_d.shreg = st_q.shreg >> 1;
                            st_d.line  = st_q.shreg[1];
                        end
                    end
                    default: begin
                        if (avail) begin
                            pop        = 1'b1;
                            st_d.state = SH_START;
                            st_d.shreg = load_data;
                            st_d.line  = 1'b0;
                        end else begin
                            st_d.state = SH_IDLE;
                            st_d.line  = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SH_IDLE;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.state != SH_IDLE);
    assign tx   = st_q.line;

    AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx)); // R8
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx) |-> (st_q.state == SH_START || st_q.state == SH_DATA)); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SH_STOP) |-> tx); // R2
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tx,
    output logic              hold_empty,
    output logic              tx_idle
);
    logic              pop;
    logic              busy;
    logic [DATA_W-1:0] head_data;

    uart_tx_hold #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .limit_one (!fifo_en),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head_data),
        .empty     (hold_empty)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .avail     (!hold_empty),
        .load_data (head_data),
        .pop       (pop),
        .busy      (busy),
        .tx        (tx)
    );

    assign tx_idle = hold_empty && !busy;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx); // R4
    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> hold_empty); // R4
endmodule

// File: tb/uart_tx_path_bench.sv
module uart_tx_path_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NVEC       = 8;
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5A5, 16'h0000, 16'hFFFF, 16'h0101,
        16'h8080, 16'h3C3C, 16'h5A5A, 16'hC3C3
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       fifo_en = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       baud_tick = 0;
    logic       tick_on = 1;
    logic       tx, hold_empty, tx_idle;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] rx_mem [64];
    int         fe_t [64];
    int         rx_cnt = 0;

    uart_tx_path u_uart_tx_path (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
        .wr_data(wr_data), .baud_tick(baud_tick), .tx(tx),
        .hold_empty(hold_empty), .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            baud_tick = tick_on && (div == DIV - 1);
            div = (div == DIV - 1) ? 0 : div + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // line decoder: samples each bit at its middle tick
    initial begin
        bit         in_frame = 0;
        int         tc = 0;
        logic [7:0] b = 0;
        forever begin
            @(negedge clk);
            if (rst_n && !in_frame && tx === 1'b0) begin
                in_frame = 1; tc = 0; fe_t[rx_cnt] = cyc;
            end
            if (in_frame && baud_tick) begin
                tc++;
                if (tc % 16 == 8) begin
                    if (tc / 16 == 0) check(tx === 1'b0, "R2 start bit", int'(tx), 0);
                    else if (tc / 16 <= 8) b[tc/16 - 1] = tx;
                    else begin
                        check(tx === 1'b1, "R2 stop bit", int'(tx), 1);
                        rx_mem[rx_cnt] = b;
                        rx_cnt++;
                        in_frame = 0;
                    end
                end
            end
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (tx_idle !== 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(tx === 1'b1, "R1 tx", int'(tx), 1);
        check(hold_empty === 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        check(tx_idle === 1'b1, "R1 tx_idle", int'(tx_idle), 1);

        // vector table: burst in queue mode, decoded stream must match in order
        fifo_en = 1;
        base = rx_cnt;
        for (int i = 0; i < NVEC; i++) write_byte(VEC[i][15:8]);
        wait_idle();
        check(rx_cnt - base == NVEC, "R6 vector count", rx_cnt - base, NVEC);
        for (int i = 0; i < NVEC; i++) begin
            check(rx_mem[base+i] === VEC[i][7:0], "R2 vector byte", int'(rx_mem[base+i]), int'(VEC[i][7:0]));
            if (i > 0)
                check(fe_t[base+i] - fe_t[base+i-1] == 160*DIV, "R7 frame spacing",
                      fe_t[base+i] - fe_t[base+i-1], 160*DIV);
        end

        // single-byte mode: transfer timing and drop when the slot is full
        fifo_en = 0;
        base = rx_cnt;
        write_byte(8'h4E);
        check(hold_empty === 1'b0, "R3 waiting byte", int'(hold_empty), 0);
        check(tx_idle === 1'b0, "R4 not idle with waiting byte", int'(tx_idle), 0);
        while (hold_empty !== 1'b1) @(negedge clk);
        check(tx === 1'b0, "R3 start begins at transfer", int'(tx), 0);
        check(tx_idle === 1'b0, "R4 busy while shifting", int'(tx_idle), 0);
        write_byte(8'hB1);
        check(hold_empty === 1'b0, "R5 write accepted", int'(hold_empty), 0);
        write_byte(8'h77);
        wait_idle();
        check(rx_cnt - base == 2, "R5 overwrite dropped", rx_cnt - base, 2);
        check(rx_mem[base] === 8'h4E, "R5 first byte", int'(rx_mem[base]), 'h4E);
        check(rx_mem[base+1] === 8'hB1, "R5 second byte", int'(rx_mem[base+1]), 'hB1);
        check(fe_t[base+1] - fe_t[base] == 160*DIV, "R7 waiting byte follows stop",
              fe_t[base+1] - fe_t[base], 160*DIV);
        check(tx_idle === 1'b1 && hold_empty === 1'b1, "R4 idle after drain", int'(tx_idle), 1);

        // queue mode: 17 writes with ticks held off, 17th is dropped
        fifo_en = 1;
        tick_on = 0;
        base = rx_cnt;
        for (int i = 0; i < 17; i++) write_byte(8'(8'h10 + i));
        repeat (40) @(negedge clk);
        check(tx === 1'b1, "R8 line still without ticks", int'(tx), 1);
        check(hold_empty === 1'b0, "R3 queue holds bytes", int'(hold_empty), 0);
        tick_on = 1;
        wait_idle();
        check(rx_cnt - base == 16, "R6 full queue drops write", rx_cnt - base, 16);
        for (int i = 0; i < 16; i++)
            check(rx_mem[base+i] === 8'(8'h10 + i), "R6 queue order",
                  int'(rx_mem[base+i]), 'h10 + i);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule